// File: doc/BRIEF.md
# Receive Packet Queue with Framing

This block is the receive buffer of a small Ethernet MAC. Frames arrive one byte per cycle on a stream with valid and last marks. Each accepted frame is written into one slot of a circular queue. While the frame is written, the block computes its CRC-32. After the last byte it appends the four CRC bytes behind the payload and writes a 16-bit length in front of it. The packet is then counted as queued.

Software drains the queue through a single 32-bit data register. Each read returns the next four stored bytes, little-endian. When the last word of a packet has been read, the slot is released and the next packet follows. A packet counter shows how many packets are waiting. A receive-event flag rises whenever a packet is stored. A FIFO-reset control pulse empties the queue at once.

Top module: `rxq_packet_queue`

## Requirements
- R1: The queue holds at most NUM_SLOTS packets (default 31). A frame whose first byte arrives while NUM_SLOTS packets are queued is discarded whole, and `pkt_count` never exceeds NUM_SLOTS.
- R2: A frame whose first byte arrives while `rx_en` is low is ignored. It is not stored, not counted and does not raise `rx_evt`.
- R3: The first stored word of a packet carries in bits 15:0 the stored length. This length is payload bytes + 6: low byte in bits 7:0, high byte in bits 15:8. The first payload byte sits in bits 23:16.
- R4: Directly after the payload come four CRC bytes, least significant byte first. The CRC is the reflected CRC-32 (polynomial 0xEDB88320, seed all ones, result inverted) over the payload bytes only.
- R5: Each read of the data register (`rd_en` for one cycle) loads `rd_data` at that clock edge with the next four stored bytes: the byte at the lowest offset goes in bits 7:0. Byte positions at or beyond the stored length read as zero.
- R6: Reading the final word of a packet advances the read slot, wrapping from NUM_SLOTS-1 to 0, and decrements `pkt_count`. Packets come out in arrival order.
- R7: A read while no packet is queued and none is partly read returns 0 and leaves `pkt_count` unchanged.
- R8: A one-cycle `fifo_rst` pulse does three things. It sets `pkt_count` to 0 on the next edge. It abandons a partly read packet, so the next stored packet is read from its length word. It abandons a frame being written, so that frame is never counted.
- R9: Storing a packet sets `rx_evt`. `rx_evt_clr` clears it, and a store in the same cycle wins over the clear.
- R10: A frame whose payload + 6 exceeds SLOT_BYTES is discarded whole. A frame of exactly SLOT_BYTES - 6 payload bytes is stored intact.
- R11: `pkt_count` rises on the fifth rising clock edge after the edge that accepted the last byte of a frame. The writer needs that many idle cycles before the next frame may start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive enable, sampled at a frame's first byte |
| fifo_rst | input | 1 | One-cycle pulse that empties the queue |
| in_valid | input | 1 | Incoming byte is valid |
| in_data | input | 8 | Incoming byte |
| in_last | input | 1 | Marks the final byte of a frame |
| rd_en | input | 1 | One-cycle data-register read strobe |
| rd_data | output | 32 | Word returned by the last read |
| pkt_count | output | $clog2(NUM_SLOTS+1) | Number of queued packets |
| rx_evt | output | 1 | Receive-event flag |
| rx_evt_clr | input | 1 | Clears the receive-event flag |

## Verification
The bench keeps the default of 31 slots but builds each slot at 32 bytes. This lets the queue be filled to its limit with one-byte frames in a few thousand cycles. It also drives the read pointer through its 30-to-0 wrap more than once. With 32-byte slots, the longest storable frame is 26 payload bytes and the first discarded one is 27, so both sides of the oversize boundary are exercised. Short payloads of 1 to 5 bytes cover every alignment of the CRC tail and of the zero padding in the final word.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_BODY,
        WS_SKIP,
        WS_CRC,
        WS_LEN
    } wr_state_e;

    typedef struct packed {
        logic [3:0]  be;
        logic [31:0] data;
    } lane_wr_t;

    localparam logic [31:0] CRC_POLY = 32'hEDB8_8320;
    localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;
    localparam int          PREFIX_BYTES = 2;
    localparam int          CRC_BYTES    = 4;
    localparam int          FRAME_EXTRA  = PREFIX_BYTES + CRC_BYTES;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
        end
        return r;
    endfunction

    function automatic lane_wr_t byte_lane(input logic [1:0] pos, input logic [7:0] b);
        lane_wr_t w;
        w.be   = 4'b0001 << pos;
        w.data = {4{b}};
        return w;
    endfunction

endpackage

// File: rtl/rxq_crc.sv
module rxq_crc
    import rxq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        step,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_out
);
    logic [31:0] acc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= CRC_SEED;
        end else if (step) begin
            acc_q <= crc_step(start ? CRC_SEED : acc_q, byte_in);
        end
    end

    assign crc_out = ~acc_q;
endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 992,
    localparam int AW = $clog2(DEPTH)
)(
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  lane_wr_t      wr,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);
    for (genvar g = 0; g < 4; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wr.be[g]) begin
                lane_mem[waddr] <= wr.data[8*g +: 8];
            end
        end

        assign rdata[8*g +: 8] = lane_mem[raddr];
    end
endmodule

// File: rtl/rxq_writer.sv
module rxq_writer
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS  = 31,
    parameter int SLOT_BYTES = 128,
    localparam int WPS   = SLOT_BYTES / 4,
    localparam int DEPTH = NUM_SLOTS * WPS,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(NUM_SLOTS),
    localparam int OW    = $clog2(SLOT_BYTES)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          fifo_rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          q_full,
    input  logic [SW-1:0] start_slot,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output lane_wr_t      mem_wr,
    output logic          commit
);
    wr_state_e     state_q, state_d;
    logic [SW-1:0] slot_q, slot_sel;
    logic [OW-1:0] n_q, off;
    logic [1:0]    k_q;
    logic [AW-1:0] base;
    logic [31:0]   crc_val;
    logic          fits, take_first, take_more;
    logic [15:0]   len16;

    assign slot_sel   = (state_q == WS_IDLE) ? start_slot : slot_q;
    assign base       = AW'(slot_sel) * AW'(WPS);
    assign fits       = (int'(n_q) + 1 + FRAME_EXTRA) <= SLOT_BYTES;
    assign take_first = (state_q == WS_IDLE) && in_valid && rx_en && !q_full && !fifo_rst;
    assign take_more  = (state_q == WS_BODY) && in_valid && !fifo_rst && fits;
    assign len16      = 16'(n_q) + 16'(FRAME_EXTRA);

    rxq_crc u_crc (
        .clk     (clk),
        .rst     (rst),
        .start   (take_first),
        .step    (take_first | take_more),
        .byte_in (in_data),
        .crc_out (crc_val)
    );

    always_comb begin
        mem_we   = 1'b0;
        mem_addr = base;
        mem_wr   = byte_lane(2'd2, in_data);
        commit   = 1'b0;
        off      = n_q + OW'(PREFIX_BYTES);
        case (state_q)
            WS_IDLE: begin
                mem_we = take_first;
            end
            WS_BODY: begin
                mem_we   = take_more;
                mem_addr = base + AW'(off[OW-1:2]);
                mem_wr   = byte_lane(off[1:0], in_data);
            end
            WS_CRC: begin
                off      = n_q + OW'(PREFIX_BYTES) + OW'(k_q);
                mem_we   = !fifo_rst;
                mem_addr = base + AW'(off[OW-1:2]);
                mem_wr   = byte_lane(off[1:0], crc_val[{k_q, 3'b000} +: 8]);
            end
            WS_LEN: begin
                mem_we      = !fifo_rst;
                mem_wr.be   = 4'b0011;
                mem_wr.data = {16'h0, len16};
                commit      = !fifo_rst;
            end
            default: ;
        endcase
    end

    always_comb begin
        state_d = state_q;
        case (state_q)
            WS_IDLE: if (in_valid) begin
                if (take_first) state_d = in_last ? WS_CRC : WS_BODY;
                else            state_d = in_last ? WS_IDLE : WS_SKIP;
            end
            WS_BODY: begin
                if (fifo_rst || (in_valid && !fits)) begin
                    state_d = (in_valid && in_last) ? WS_IDLE : WS_SKIP;
                end else if (in_valid && in_last) begin
                    state_d = WS_CRC;
                end
            end
            WS_SKIP: if (in_valid && in_last) state_d = WS_IDLE;
            WS_CRC: begin
                if (fifo_rst)            state_d = WS_IDLE;
                else if (k_q == 2'd3)    state_d = WS_LEN;
            end
            WS_LEN:  state_d = WS_IDLE;
            default: state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= WS_IDLE;
            slot_q  <= '0;
            n_q     <= '0;
            k_q     <= '0;
        end else begin
            state_q <= state_d;
            if (take_first) begin
                slot_q <= start_slot;
                n_q    <= OW'(1);
            end else if (take_more) begin
                n_q <= n_q + OW'(1);
            end
            k_q <= (state_q == WS_CRC) ? k_q + 2'd1 : 2'd0;
        end
    end

    // R2: a frame starting while receive is disabled never enters the store path
    p_disabled_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_IDLE && in_valid && !rx_en) |=> (state_q != WS_BODY && state_q != WS_CRC));

    // R1: a frame starting while the queue is full is not stored
    p_full_drop_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_IDLE && in_valid && q_full) |=> (state_q != WS_BODY && state_q != WS_CRC));

    // R11: no new frame may start while the tail is being written
    p_tail_gap_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_CRC || state_q == WS_LEN) |-> !in_valid);

    // R10: the body offset never reaches the CRC area of the next slot
    p_slot_bound_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == WS_BODY) |-> (int'(n_q) + FRAME_EXTRA <= SLOT_BYTES));
endmodule

// File: rtl/rxq_reader.sv
module rxq_reader
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS  = 31,
    parameter int SLOT_BYTES = 128,
    localparam int WPS   = SLOT_BYTES / 4,
    localparam int DEPTH = NUM_SLOTS * WPS,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(NUM_SLOTS),
    localparam int CW    = $clog2(NUM_SLOTS + 1),
    localparam int WIW   = $clog2(SLOT_BYTES) - 2
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_rst,
    input  logic          rd_en,
    input  logic [CW-1:0] count,
    input  logic [31:0]   mem_rdata,
    output logic [AW-1:0] mem_raddr,
    output logic [31:0]   rd_data,
    output logic          pop,
    output logic [SW-1:0] rd_ptr
);
    logic [SW-1:0]  ptr_q;
    logic [WIW-1:0] widx_q;
    logic [15:0]    len_q, eff_len;
    logic           in_pkt_q, have, last;
    logic [31:0]    masked;

    assign rd_ptr    = ptr_q;
    assign mem_raddr = AW'(ptr_q) * AW'(WPS) + AW'(widx_q);
    assign eff_len   = in_pkt_q ? len_q : mem_rdata[15:0];
    assign have      = in_pkt_q || (count != '0);
    assign last      = ((int'(widx_q) + 1) * 4) >= int'(eff_len);
    assign pop       = rd_en && !fifo_rst && have && last;

    always_comb begin
        for (int j = 0; j < 4; j++) begin
            masked[8*j +: 8] = ((int'(widx_q) * 4 + j) < int'(eff_len)) ? mem_rdata[8*j +: 8] : 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q    <= '0;
            widx_q   <= '0;
            len_q    <= '0;
            in_pkt_q <= 1'b0;
            rd_data  <= '0;
        end else if (fifo_rst) begin
            widx_q   <= '0;
            in_pkt_q <= 1'b0;
        end else if (rd_en) begin
            if (!have) begin
                rd_data <= '0;
            end else begin
                rd_data <= masked;
                if (last) begin
                    in_pkt_q <= 1'b0;
                    widx_q   <= '0;
                    ptr_q    <= (ptr_q == SW'(NUM_SLOTS - 1)) ? '0 : ptr_q + SW'(1);
                end else begin
                    in_pkt_q <= 1'b1;
                    widx_q   <= widx_q + WIW'(1);
                    len_q    <= eff_len;
                end
            end
        end
    end

    // R7: an empty read returns zero
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !fifo_rst && count == '0 && !in_pkt_q) |=> (rd_data == 32'h0));

    // R6: the read slot stays inside the ring
    p_ptr_range_r6: assert property (@(posedge clk) disable iff (rst)
        int'(ptr_q) < NUM_SLOTS);

    // R6: releasing a slot moves the pointer by exactly one, with wrap
    p_ptr_advance_r6: assert property (@(posedge clk) disable iff (rst)
        pop |=> (ptr_q == (($past(ptr_q) == SW'(NUM_SLOTS - 1)) ? '0 : $past(ptr_q) + SW'(1))));
endmodule

// File: rtl/rxq_packet_queue.sv
module rxq_packet_queue
    import rxq_pkg::*;
#(
    parameter int NUM_SLOTS  = 31,
    parameter int SLOT_BYTES = 128,
    localparam int WPS   = SLOT_BYTES / 4,
    localparam int DEPTH = NUM_SLOTS * WPS,
    localparam int AW    = $clog2(DEPTH),
    localparam int SW    = $clog2(NUM_SLOTS),
    localparam int CW    = $clog2(NUM_SLOTS + 1)
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          fifo_rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    input  logic          rd_en,
    output logic [31:0]   rd_data,
    output logic [CW-1:0] pkt_count,
    output logic          rx_evt,
    input  logic          rx_evt_clr
);
    logic          mem_we, commit, pop, q_full;
    logic [AW-1:0] waddr, raddr;
    lane_wr_t      wr;
    logic [31:0]   rdata;
    logic [SW-1:0] rd_ptr, start_slot;
    logic [CW-1:0] count_q;

    assign q_full    = (count_q == CW'(NUM_SLOTS));
    assign pkt_count = count_q;

    always_comb begin
        int s;
        s = int'(rd_ptr) + int'(count_q);
        if (s >= NUM_SLOTS) s = s - NUM_SLOTS;
        start_slot = SW'(s);
    end

    rxq_writer #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_writer (
        .clk        (clk),
        .rst        (rst),
        .rx_en      (rx_en),
        .fifo_rst   (fifo_rst),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_last    (in_last),
        .q_full     (q_full),
        .start_slot (start_slot),
        .mem_we     (mem_we),
        .mem_addr   (waddr),
        .mem_wr     (wr),
        .commit     (commit)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr (waddr),
        .wr    (wr),
        .raddr (raddr),
        .rdata (rdata)
    );

    rxq_reader #(.NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES)) u_reader (
        .clk       (clk),
        .rst       (rst),
        .fifo_rst  (fifo_rst),
        .rd_en     (rd_en),
        .count     (count_q),
        .mem_rdata (rdata),
        .mem_raddr (raddr),
        .rd_data   (rd_data),
        .pop       (pop),
        .rd_ptr    (rd_ptr)
    );

    always_ff @(posedge clk) begin
        if (rst || fifo_rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_q + CW'(commit) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)             rx_evt <= 1'b0;
        else if (commit)     rx_evt <= 1'b1;
        else if (rx_evt_clr) rx_evt <= 1'b0;
    end

    // R1: the count never exceeds the slot count
    p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
        int'(pkt_count) <= NUM_SLOTS);

    // R8: a FIFO reset empties the queue on the next edge
    p_fifo_clear_r8: assert property (@(posedge clk) disable iff (rst)
        fifo_rst |=> (pkt_count == '0));

    // R9: a stored packet raises the event flag
    p_store_evt_r9: assert property (@(posedge clk) disable iff (rst)
        commit |=> rx_evt);

    // R6: finishing a packet read alone drops the count by one
    p_pop_dec_r6: assert property (@(posedge clk) disable iff (rst)
        (pop && !commit && !fifo_rst) |=> (pkt_count == $past(pkt_count) - CW'(1)));
endmodule

// File: tb/rxq_packet_queue_bench.sv
module rxq_packet_queue_bench;
    localparam int N  = 31;
    localparam int SB = 32;
    localparam int CW = $clog2(N + 1);
    localparam int NV = 7;
    localparam int VEC [NV][3] = '{
        '{1, 'hA5, 0}, '{2, 'h10, 1}, '{3, 'hF0, 3}, '{4, 0, 17},
        '{5, 'h80, 255}, '{13, 'h33, 7}, '{26, 1, 1}
    };

    logic clk = 1'b0, rst = 1'b1, rx_en = 1'b1, fifo_rst = 1'b0;
    logic in_valid = 1'b0, in_last = 1'b0, rd_en = 1'b0, rx_evt_clr = 1'b0;
    logic [7:0] in_data = 8'h0;
    logic [31:0] rd_data;
    logic [CW-1:0] pkt_count;
    logic rx_evt;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [7:0] pl [64];

    always #10 clk = ~clk;

    rxq_packet_queue #(.NUM_SLOTS(N), .SLOT_BYTES(SB)) u_rxq_packet_queue (
        .clk(clk), .rst(rst), .rx_en(rx_en), .fifo_rst(fifo_rst),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .rd_en(rd_en), .rd_data(rd_data), .pkt_count(pkt_count),
        .rx_evt(rx_evt), .rx_evt_clr(rx_evt_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_crc(input int len);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'h0, pl[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    function automatic logic [7:0] exp_byte(input int idx, input int len, input logic [31:0] crc);
        int total = len + 6;
        if (idx == 0) return 8'(total);
        if (idx == 1) return 8'(total >> 8);
        if (idx < len + 2) return pl[idx - 2];
        if (idx < total) return crc[8*(idx - len - 2) +: 8];
        return 8'h00;
    endfunction

    task automatic send(input int len, input int b0, input int step);
        for (int i = 0; i < len; i++) begin
            pl[i]    = 8'((b0 + i * step) & 255);
            in_valid = 1'b1;
            in_data  = pl[i];
            in_last  = (i == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic rd_word(output logic [31:0] w);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        w = rd_data;
    endtask

    task automatic check_pkt(input int len, input string tag);
        logic [31:0] crc = ref_crc(len);
        int nw = (len + 6 + 3) / 4;
        for (int w = 0; w < nw; w++) begin
            logic [31:0] got, exp;
            rd_word(got);
            for (int j = 0; j < 4; j++) exp[8*j +: 8] = exp_byte(4*w + j, len, crc);
            chk(tag, got, exp);
        end
    endtask

    task automatic pulse_fifo_rst();
        fifo_rst = 1'b1;
        @(negedge clk);
        fifo_rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state (R7, R9)
        chk("R7 reset count", 32'(pkt_count), 0);
        chk("R9 reset evt", 32'(rx_evt), 0);
        rd_word(w);
        chk("R7 empty read", w, 0);
        chk("R7 empty count", 32'(pkt_count), 0);

        // vector table: R3 R4 R5 R6 R9
        for (int v = 0; v < NV; v++) begin
            send(VEC[v][0], VEC[v][1], VEC[v][2]);
            chk("R9 evt set", 32'(rx_evt), 1);
            chk("R6 count one", 32'(pkt_count), 1);
            check_pkt(VEC[v][0], "R3 R4 R5 packet");
            chk("R6 count drained", 32'(pkt_count), 0);
            rx_evt_clr = 1'b1;
            @(negedge clk);
            rx_evt_clr = 1'b0;
            chk("R9 evt clear", 32'(rx_evt), 0);
        end

        // R11: count rises on the fifth edge after the last byte
        pl[0] = 8'h5A;
        in_valid = 1'b1; in_data = 8'h5A; in_last = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 before commit", 32'(pkt_count), 0);
        @(negedge clk);
        chk("R11 at commit", 32'(pkt_count), 1);
        @(negedge clk);
        check_pkt(1, "R11 packet");
        rx_evt_clr = 1'b1; @(negedge clk); rx_evt_clr = 1'b0;

        // R2: disabled receive
        rx_en = 1'b0;
        send(4, 'h44, 1);
        chk("R2 not counted", 32'(pkt_count), 0);
        chk("R2 no evt", 32'(rx_evt), 0);
        rx_en = 1'b1;
        rd_word(w);
        chk("R2 R7 nothing stored", w, 0);

        // R10: oversize frame
        send(27, 'h20, 1);
        chk("R10 oversize dropped", 32'(pkt_count), 0);
        send(26, 'h60, 2);
        chk("R10 max stored", 32'(pkt_count), 1);
        check_pkt(26, "R10 max packet");

        // R1 / R6: fill, overflow, drain with wrap
        for (int i = 0; i < N; i++) send(1, i + 16, 0);
        chk("R1 full", 32'(pkt_count), N);
        send(1, 'hEE, 0);
        chk("R1 overflow dropped", 32'(pkt_count), N);
        for (int i = 0; i < N; i++) begin
            pl[0] = 8'(i + 16);
            check_pkt(1, "R6 order");
        end
        chk("R6 all drained", 32'(pkt_count), 0);

        // R8: reset during partial read
        send(10, 'h01, 5);
        send(5, 'h90, 1);
        rd_word(w);
        pulse_fifo_rst();
        chk("R8 count cleared", 32'(pkt_count), 0);
        send(3, 'h70, 1);
        check_pkt(3, "R8 fresh packet");

        // R8: reset during frame write
        for (int i = 0; i < 6; i++) begin
            in_valid = 1'b1; in_data = 8'(i); in_last = (i == 5); fifo_rst = (i == 2);
            @(negedge clk);
        end
        in_valid = 1'b0; in_last = 1'b0; fifo_rst = 1'b0;
        repeat (6) @(negedge clk);
        chk("R8 write abandoned", 32'(pkt_count), 0);
        send(2, 'hC3, 1);
        check_pkt(2, "R8 after abort");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule